// File: doc/BRIEF.md
# Overlay Window Signature Probe

This block checks whether a phase-change memory is present behind a simple word-addressed bus. It does this by asking the memory to expose its control overlay and then reading a known identification tag from that overlay. A single `start` pulse runs the whole sequence. Two writes on the mode-register port open the overlay. Four reads on the bus master then fetch the tag words. Two more mode-register writes close the overlay again. At the end the block pulses `done` and reports the result on `found`.

The data width is set by a parameter. With two bytes it serves one x16 device; with four bytes it serves two x16 devices stacked as x32. The width changes two things. Each overlay word's bus address is the window base plus the word index times the data width in bytes. In the x32 case the enable bit of the mode-register configuration value moves up into the upper half-word.

Top module: `owin_sig_probe`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `bus_valid` and `mr_we` are all low.
- R2: A start that is accepted while idle first issues a configuration write (`mr_sel`=0). Its value is 0x0000_8018 when BUS_BYTES=2 and 0x8000_0018 when BUS_BYTES=4. A data write (`mr_sel`=1) of 0x01 follows, which opens the overlay.
- R3: With the overlay open, the block makes exactly four reads, at addresses WIN_BASE + k*BUS_BYTES for k = 0, 1, 2, 3, in that order. Each read is issued only after the previous read's `rd_valid` has arrived.
- R4: After the fourth read word arrives, the block writes the same configuration value, then a data write of 0x02 that closes the overlay. This close happens on every run, whatever the comparison result.
- R5: `found` becomes 1 when the four words are 0x50, 0x46, 0x4F and 0x57 (the letters P, F, O, W), each zero-extended to the full data width, arriving in read order.
- R6: A single wrong word in any position gives `found`=0. A word whose low byte is right but whose upper bits are not zero also counts as wrong.
- R7: `done` is high for exactly one cycle, the cycle after the close data write is accepted. `found` is valid while `done` is high and holds until the next accepted start, which clears it.
- R8: A `start` that arrives while `busy` is high is ignored; no extra mode-register write or bus read results from it.
- R9: `bus_valid` with `bus_addr`, and `mr_we` with its `mr_sel`/`mr_wdata`, stay stable until their ready signals arrive. The bus and the mode-register port are never requested in the same cycle. A `rd_valid` that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one probe sequence (accepted only while idle) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| found | output | 1 | Tag matched on the last completed sequence |
| mr_we | output | 1 | Mode-register write request |
| mr_sel | output | 1 | 0 = configuration register, 1 = data register |
| mr_wdata | output | 32 | Mode-register write value |
| mr_ready | input | 1 | Mode-register write accepted |
| bus_valid | output | 1 | Read request on the memory bus |
| bus_addr | output | ADDR_W | Byte address of the requested overlay word |
| bus_ready | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 8*BUS_BYTES | Read data word |

## Verification
The bench runs every case at both widths, because two faults can only appear at one width. An unshifted or unscaled x32 configuration value would go out as 0x8018. An address stride of two bytes would read the wrong overlay words. The bench corrupts each tag position in turn and also sends a word with stray upper bits. A comparator that checked only the low byte, or that let the last word decide the result, would then report a false match. It sends a second start in the middle of a run and a stray read strobe while idle. A design that restarted would show up as extra accesses that the scoreboard does not expect. A design that took the stray strobe as data would report a false result.

// File: rtl/owin_sig_probe.sv
module owin_sig_probe #(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W    = 32,
  parameter int WIN_BASE  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   found,
  output logic                   mr_we,
  output logic                   mr_sel,
  output logic [31:0]            mr_wdata,
  input  logic                   mr_ready,
  output logic                   bus_valid,
  output logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_ready,
  input  logic                   rd_valid,
  input  logic [8*BUS_BYTES-1:0] rd_data
);
  localparam int DW = 8 * BUS_BYTES;
  localparam logic [31:0] CFG_VAL =
    ((BUS_BYTES == 4) ? 32'h8000_0000 : 32'h0000_8000) | 32'h0000_0018;

  typedef enum logic [2:0] {
    S_IDLE, S_OCFG, S_ODAT, S_RREQ, S_RWAIT, S_CCFG, S_CDAT, S_DONE
  } st_t;

  st_t        st;
  logic [1:0] idx;
  logic       ok;

  function automatic logic [7:0] tag_char(input logic [1:0] k);
    case (k)
      2'd0:    tag_char = 8'h50;
      2'd1:    tag_char = 8'h46;
      2'd2:    tag_char = 8'h4F;
      default: tag_char = 8'h57;
    endcase
  endfunction

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign mr_we     = (st == S_OCFG) || (st == S_ODAT) || (st == S_CCFG) || (st == S_CDAT);
  assign mr_sel    = (st == S_ODAT) || (st == S_CDAT);
  assign mr_wdata  = (st == S_ODAT) ? 32'h1 : (st == S_CDAT) ? 32'h2 : CFG_VAL;
  assign bus_valid = (st == S_RREQ);
  assign bus_addr  = ADDR_W'(WIN_BASE) + ADDR_W'(idx) * ADDR_W'(BUS_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      ok    <= 1'b0;
      found <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_OCFG;
          idx   <= '0;
          ok    <= 1'b1;
          found <= 1'b0;
        end
        S_OCFG: if (mr_ready) st <= S_ODAT;
        S_ODAT: if (mr_ready) st <= S_RREQ;
        S_RREQ: if (bus_ready) st <= S_RWAIT;
        S_RWAIT: if (rd_valid) begin
          ok <= ok && (rd_data == DW'(tag_char(idx)));
          if (idx == 2'd3) st <= S_CCFG;
          else begin
            idx <= idx + 2'd1;
            st  <= S_RREQ;
          end
        end
        S_CCFG: if (mr_ready) st <= S_CDAT;
        S_CDAT: if (mr_ready) begin
          found <= ok;
          st    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_open_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mr_we && !mr_sel));
  a_r4_close_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_we && mr_ready && mr_sel && mr_wdata == 32'h2) |=> done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_found_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> done);
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));
  a_r9_mr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_we && !mr_ready) |=> (mr_we && $stable(mr_sel) && $stable(mr_wdata)));
  a_r9_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && mr_we));
endmodule

// File: tb/owin_sig_probe_test.sv
module owin_probe_lane #(parameter int BB = 2) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic fin
);
  localparam int DW = 8 * BB;
  localparam logic [31:0] CFG = (BB == 4) ? 32'h8000_0018 : 32'h0000_8018;

  logic start, busy, done, found, mr_we, mr_sel, mr_ready;
  logic [31:0] mr_wdata, bus_addr;
  logic bus_valid, bus_ready, rd_v, spur;
  logic [DW-1:0] rd_d, sig [4];
  int lat, rlat, bw, mw, pcnt;
  logic pend;
  logic [31:0] paddr;

  logic [32:0] q_mr [$];
  logic [31:0] q_addr [$];
  bit          q_found [$];

  owin_sig_probe #(.BUS_BYTES(BB), .ADDR_W(32), .WIN_BASE(0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .found(found),
    .mr_we(mr_we), .mr_sel(mr_sel), .mr_wdata(mr_wdata), .mr_ready(mr_ready),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_ready(bus_ready),
    .rd_valid(rd_v | spur), .rd_data(spur ? {DW{1'b1}} : rd_d));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL x%0d %s act=%0h exp=%0h", BB*8, req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 0; mr_ready <= 0; rd_v <= 0; rd_d <= '0;
      bw <= 0; mw <= 0; pend <= 0; pcnt <= 0; paddr <= '0;
    end else begin
      bus_ready <= 0;
      if (bus_valid && !bus_ready) begin
        if (bw >= lat) begin bus_ready <= 1; bw <= 0; end else bw <= bw + 1;
      end
      mr_ready <= 0;
      if (mr_we && !mr_ready) begin
        if (mw >= lat) begin mr_ready <= 1; mw <= 0; end else mw <= mw + 1;
      end
      rd_v <= 0;
      if (bus_valid && bus_ready) begin
        pend <= 1; pcnt <= 0; paddr <= bus_addr;
      end else if (pend) begin
        if (pcnt >= rlat) begin
          rd_v <= 1; rd_d <= sig[(paddr / BB) % 4]; pend <= 0;
        end else pcnt <= pcnt + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (bus_valid && bus_ready) begin
      check(q_addr.size() > 0, "R8 unexpected read", 64'(bus_addr), 0);
      if (q_addr.size() > 0) begin
        logic [31:0] ea;
        ea = q_addr.pop_front();
        check(bus_addr == ea, "R3 read address", 64'(bus_addr), 64'(ea));
      end
    end
    if (mr_we && mr_ready) begin
      check(q_mr.size() > 0, "R8 unexpected mode write", 64'({mr_sel, mr_wdata}), 0);
      if (q_mr.size() > 0) begin
        logic [32:0] em;
        em = q_mr.pop_front();
        check({mr_sel, mr_wdata} == em, "R2/R4 mode write", 64'({mr_sel, mr_wdata}), 64'(em));
      end
    end
    if (done) begin
      check(q_found.size() > 0, "R7 unexpected done", 64'(found), 0);
      if (q_found.size() > 0) begin
        bit ef;
        ef = q_found.pop_front();
        check(found == ef, "R5/R6 found at done", 64'(found), 64'(ef));
      end
    end
  end

  task automatic run(input logic [DW-1:0] a, b, c, d, input bit want,
                     input int l, input int r, input bit poke);
    int t;
    sig[0] = a; sig[1] = b; sig[2] = c; sig[3] = d;
    lat = l; rlat = r;
    q_mr.push_back({1'b0, CFG});
    q_mr.push_back({1'b1, 32'h1});
    for (int k = 0; k < 4; k++) q_addr.push_back(32'(k * BB));
    q_mr.push_back({1'b0, CFG});
    q_mr.push_back({1'b1, 32'h2});
    q_found.push_back(want);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(found == 0 && busy, "R7 found cleared on start", 64'({busy, found}), 64'h2);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(done, "R7 done reached", 64'(done), 1);
    @(negedge clk);
    check(!done, "R7 done one cycle", 64'(done), 0);
    check(found == want, "R7 found held", 64'(found), 64'(want));
    repeat (4) @(negedge clk);
    check(found == want && !busy, "R8 idle with result kept", 64'({busy, found}), 64'(want));
    check(q_mr.size() == 0 && q_addr.size() == 0, "R4 all accesses seen",
          64'(q_mr.size() + q_addr.size()), 0);
  endtask

  localparam logic [DW-1:0] CP = DW'(8'h50), CF = DW'(8'h46), CO = DW'(8'h4F), CW = DW'(8'h57);

  initial begin
    n_chk = 0; n_bad = 0; fin = 0; start = 0; spur = 0; lat = 0; rlat = 0;
    for (int k = 0; k < 4; k++) sig[k] = '0;
    wait (rst_n);
    @(negedge clk);
    check(!busy && !done && !found && !bus_valid && !mr_we, "R1 reset state",
          64'({busy, done, found, bus_valid, mr_we}), 0);
    run(CP, CF, CO, CW, 1, 0, 0, 0);
    run(CP, CF, CO, CW, 1, 2, 3, 0);
    run(CO, CF, CO, CW, 0, 0, 1, 0);
    run(CP, CP, CO, CW, 0, 1, 0, 0);
    run(CP, CF, CF, CW, 0, 0, 0, 0);
    run(CP, CF, CO, CP, 0, 3, 2, 0);
    run(DW'(16'h0150), CF, CO, CW, 0, 0, 0, 0);
    run(CP, CF, CO, CW | DW'(16'h8000), 0, 0, 0, 0);
    run('0, '0, '0, '0, 0, 0, 0, 0);
    run(CP, CF, CO, CW, 1, 1, 1, 1);
    @(negedge clk) spur = 1;
    @(negedge clk) spur = 0;
    check(!busy && found, "R9 stray strobe ignored while idle", 64'({busy, found}), 1);
    run(CP, CF, CO, CW, 1, 0, 2, 0);
    fin = 1;
  end
endmodule

module owin_sig_probe_test;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  int c16, b16, c32, b32, cyc;
  logic f16, f32;

  owin_probe_lane #(.BB(2)) lane16 (.clk(clk), .rst_n(rst_n), .n_chk(c16), .n_bad(b16), .fin(f16));
  owin_probe_lane #(.BB(4)) lane32 (.clk(clk), .rst_n(rst_n), .n_chk(c32), .n_bad(b32), .fin(f32));

  initial begin
    int tot, bad;
    cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    while (!(f16 && f32) && cyc < 100000) begin @(posedge clk); cyc++; end
    tot = c16 + c32;
    bad = b16 + b32;
    if (!(f16 && f32)) begin
      tot++; bad++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule